// File: doc/BRIEF.md
# ATA Task-File Window with Hidden Timing Configuration

This block sits between a host register bus and the task-file registers of a legacy ATA channel. While locked, every read and write on the host side goes straight to the drive side, and read data comes back from the drive. A fixed sequence of accesses on that same window switches it into a configuration mode. In configuration mode the window offsets no longer reach the drive. They address a small set of timing and control registers instead.

In configuration mode, software first picks a device through the select bit of the miscellaneous register. It then loads that device's read-cycle and write-cycle timing bytes and sets the shared address-setup code in the upper nibble of the miscellaneous register. A commit write to the control register copies everything to the per-device timing outputs. Until that write, the bus cycle logic keeps seeing the previous complete set. A relock write brings back normal pass-through. A strap register reports the bus clock strap captured at reset.

Top module: `ata_cfg_window`

## Requirements
- R1: After reset the window is locked (`cfg_open`=0). Every device timing byte on `tim_rd_o` and `tim_wr_o` is 0xFF. `setup_o` is 0x30. The strap register holds the value of `strap_clk25` at reset.
- R2: While locked, each host read or write is forwarded to the drive side with the same offset, size and data. `host_rdata` returns `drv_rdata`.
- R3: Two 16-bit reads at offset 1 followed by an 8-bit write of 0x03 at offset 2 open the configuration mode. These are counted as consecutive accesses, and `cfg_open` is 1 from the next cycle.
- R4: If the sequence is broken, the window stays locked. A break is any other access in between: a byte-sized read at offset 1, a read at another offset, or a write at offset 2 with a value other than 0x03.
- R5: While open, no host access reaches the drive side, and reads return configuration registers zero-extended to 16 bits. Offsets are: 0 read timing, 1 write timing, 3 control, 5 strap, 6 miscellaneous. Unused offsets read 0.
- R6: Bit 0 of the miscellaneous register picks the device bank that offsets 0 and 1 write and read back.
- R7: Writing 0x85 to offset 3 copies both staged banks to the outputs. Device n uses bits [8n+7:8n]. Any other control value is stored but leaves the outputs unchanged.
- R8: At commit, `setup_o` takes the miscellaneous register's upper nibble, shifted to bits 7:4. One code is shared by both devices.
- R9: Offset 5 reads the strap in bit 0 (0 = 33 MHz, 1 = 25 MHz). Writes to offset 5 are ignored.
- R10: An 8-bit write of 0x83 at offset 2 while open relocks the window. Other values at offset 2 leave it open. Committed timings persist after relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_addr | input | 3 | Window offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| drv_rd | output | 1 | Forwarded read strobe |
| drv_wr | output | 1 | Forwarded write strobe |
| drv_wide | output | 1 | Forwarded access size |
| drv_addr | output | 3 | Forwarded offset |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Drive-side read data |
| strap_clk25 | input | 1 | Bus clock strap pin, captured during reset |
| cfg_open | output | 1 | 1 while configuration mode is active |
| tim_rd_o | output | 16 | Committed read timing, one byte per device |
| tim_wr_o | output | 16 | Committed write timing, one byte per device |
| setup_o | output | 8 | Committed shared address-setup code |

## Verification
The hardest state to reach is a nearly complete unlock sequence that is then spoiled by a single access differing only in size or value. The stimulus builds the two wide reads and then sends a byte read, or a write with the wrong value. It then checks that the next offset-0 read still comes from the drive. A second hard case is a half-programmed bank with a non-commit control value written. The bench stages different bytes for both devices, writes 0x84, and confirms the outputs still show the reset timings before the 0x85 commit.

// File: rtl/ata_cfg_pkg.sv
package ata_cfg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int REG_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_RD_TIM = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_WR_TIM = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_KEY    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STRAP  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MISC   = 3'd6;

    localparam logic [REG_W-1:0] KEY_OPEN   = 8'h03;
    localparam logic [REG_W-1:0] KEY_CLOSE  = 8'h83;
    localparam logic [REG_W-1:0] CTRL_APPLY = 8'h85;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ONE,
        SQ_TWO,
        SQ_OPEN
    } seq_e;

    typedef struct packed {
        logic [REG_W-1:0] rd_tim;
        logic [REG_W-1:0] wr_tim;
    } tim_pair_t;

    function automatic logic is_key_read(logic rd, logic wide, logic [ADDR_W-1:0] a);
        return rd && wide && (a == OFS_WR_TIM);
    endfunction

    function automatic logic is_key_write(logic wr, logic wide, logic [ADDR_W-1:0] a,
                                          logic [REG_W-1:0] d, logic [REG_W-1:0] key);
        return wr && !wide && (a == OFS_KEY) && (d == key);
    endfunction
endpackage

// File: rtl/acw_unlock_seq.sv
module acw_unlock_seq
    import ata_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wbyte,
    output logic              open
);
    seq_e state_q, state_d;
    logic k_rd, k_open, k_close;

    assign k_rd    = is_key_read(rd, wide, addr);
    assign k_open  = is_key_write(wr, wide, addr, wbyte, KEY_OPEN);
    assign k_close = is_key_write(wr, wide, addr, wbyte, KEY_CLOSE);

    always_comb begin
        state_d = state_q;
        if (rd || wr) begin
            unique case (state_q)
                SQ_IDLE: state_d = k_rd ? SQ_ONE : SQ_IDLE;
                SQ_ONE:  state_d = k_rd ? SQ_TWO : SQ_IDLE;
                SQ_TWO:  state_d = k_rd ? SQ_TWO : (k_open ? SQ_OPEN : SQ_IDLE);
                SQ_OPEN: state_d = k_close ? SQ_IDLE : SQ_OPEN;
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    assign open = (state_q == SQ_OPEN);

    // R3
    open_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open) |-> $past(wr && !wide && addr == OFS_KEY && wbyte == KEY_OPEN));

    // R10
    open_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(open) |-> $past(wr && !wide && addr == OFS_KEY && wbyte == KEY_CLOSE));
endmodule

// File: rtl/acw_timing_bank.sv
module acw_timing_bank
    import ata_cfg_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter logic [REG_W-1:0] TIM_RESET = 8'hFF,
    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         sel,
    input  logic                     ld_rd,
    input  logic                     ld_wr,
    input  logic [REG_W-1:0]         wbyte,
    input  logic                     commit,
    output tim_pair_t                sel_stage,
    output logic [NUM_DEV*REG_W-1:0] act_rd,
    output logic [NUM_DEV*REG_W-1:0] act_wr
);
    tim_pair_t stage_q [NUM_DEV];
    logic [NUM_DEV*REG_W-1:0] stage_rd_flat, stage_wr_flat;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= '{rd_tim: TIM_RESET, wr_tim: TIM_RESET};
                act_rd[g*REG_W +: REG_W] <= TIM_RESET;
                act_wr[g*REG_W +: REG_W] <= TIM_RESET;
            end else begin
                if (ld_rd && sel == SEL_W'(g)) stage_q[g].rd_tim <= wbyte;
                if (ld_wr && sel == SEL_W'(g)) stage_q[g].wr_tim <= wbyte;
                if (commit) begin
                    act_rd[g*REG_W +: REG_W] <= stage_q[g].rd_tim;
                    act_wr[g*REG_W +: REG_W] <= stage_q[g].wr_tim;
                end
            end
        end
        assign stage_rd_flat[g*REG_W +: REG_W] = stage_q[g].rd_tim;
        assign stage_wr_flat[g*REG_W +: REG_W] = stage_q[g].wr_tim;
    end

    assign sel_stage = stage_q[sel];

    // R7
    apply_copy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (act_rd == $past(stage_rd_flat)) && (act_wr == $past(stage_wr_flat)));

    // R7
    apply_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> ($stable(act_rd) && $stable(act_wr)));
endmodule

// File: rtl/ata_cfg_window.sv
module ata_cfg_window
    import ata_cfg_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter logic [REG_W-1:0] TIM_RESET = 8'hFF,
    parameter logic [3:0] SETUP_RESET = 4'h3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_rd,
    input  logic                     host_wr,
    input  logic                     host_wide,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     drv_rd,
    output logic                     drv_wr,
    output logic                     drv_wide,
    output logic [ADDR_W-1:0]        drv_addr,
    output logic [DATA_W-1:0]        drv_wdata,
    input  logic [DATA_W-1:0]        drv_rdata,
    input  logic                     strap_clk25,
    output logic                     cfg_open,
    output logic [NUM_DEV*REG_W-1:0] tim_rd_o,
    output logic [NUM_DEV*REG_W-1:0] tim_wr_o,
    output logic [REG_W-1:0]         setup_o
);
    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic             open;
    logic             cfg_wr;
    logic             commit;
    logic [REG_W-1:0] ctrl_q, misc_q, cfg_rbyte;
    logic [3:0]       setup_q;
    logic             strap_q;
    tim_pair_t        sel_stage;

    acw_unlock_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .rd    (host_rd),
        .wr    (host_wr),
        .wide  (host_wide),
        .addr  (host_addr),
        .wbyte (host_wdata[REG_W-1:0]),
        .open  (open)
    );

    assign cfg_wr = open && host_wr;
    assign commit = cfg_wr && host_addr == OFS_CTRL && host_wdata[REG_W-1:0] == CTRL_APPLY;

    acw_timing_bank #(.NUM_DEV(NUM_DEV), .TIM_RESET(TIM_RESET)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .sel       (misc_q[SEL_W-1:0]),
        .ld_rd     (cfg_wr && host_addr == OFS_RD_TIM),
        .ld_wr     (cfg_wr && host_addr == OFS_WR_TIM),
        .wbyte     (host_wdata[REG_W-1:0]),
        .commit    (commit),
        .sel_stage (sel_stage),
        .act_rd    (tim_rd_o),
        .act_wr    (tim_wr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            misc_q  <= '0;
            setup_q <= SETUP_RESET;
            strap_q <= strap_clk25;
        end else begin
            if (cfg_wr && host_addr == OFS_CTRL) ctrl_q <= host_wdata[REG_W-1:0];
            if (cfg_wr && host_addr == OFS_MISC) misc_q <= host_wdata[REG_W-1:0];
            if (commit) setup_q <= misc_q[7:4];
        end
    end

    always_comb begin
        unique case (host_addr)
            OFS_RD_TIM: cfg_rbyte = sel_stage.rd_tim;
            OFS_WR_TIM: cfg_rbyte = sel_stage.wr_tim;
            OFS_CTRL:   cfg_rbyte = ctrl_q;
            OFS_STRAP:  cfg_rbyte = {7'd0, strap_q};
            OFS_MISC:   cfg_rbyte = misc_q;
            default:    cfg_rbyte = '0;
        endcase
    end

    assign host_rdata = open ? {{(DATA_W-REG_W){1'b0}}, cfg_rbyte} : drv_rdata;
    assign drv_rd     = host_rd && !open;
    assign drv_wr     = host_wr && !open;
    assign drv_wide   = host_wide;
    assign drv_addr   = host_addr;
    assign drv_wdata  = host_wdata;
    assign cfg_open   = open;
    assign setup_o    = {setup_q, 4'h0};

    // R9
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(strap_q));

    // R8
    setup_apply_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(setup_o));
endmodule

// File: tb/ata_cfg_window_tb_top.sv
module ata_cfg_window_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rd = 0, host_wr = 0, host_wide = 0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata, drv_wdata, drv_rdata;
    logic        drv_rd, drv_wr, drv_wide, cfg_open;
    logic [2:0]  drv_addr;
    logic        strap_clk25 = 1'b1;
    logic [15:0] tim_rd_o, tim_wr_o;
    logic [7:0]  setup_o;

    always #(PERIOD/2) clk = ~clk;

    assign drv_rdata = {8'hA5, 5'd0, drv_addr};

    ata_cfg_window dut_i (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .drv_rd(drv_rd), .drv_wr(drv_wr),
        .drv_wide(drv_wide), .drv_addr(drv_addr), .drv_wdata(drv_wdata),
        .drv_rdata(drv_rdata), .strap_clk25(strap_clk25), .cfg_open(cfg_open),
        .tim_rd_o(tim_rd_o), .tim_wr_o(tim_wr_o), .setup_o(setup_o)
    );

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    event  smp;

    // monitor: kind 0 rdata, 1 tim_rd, 2 tim_wr, 3 setup, 4 open, 5 forwarded strobe
    always begin
        @(smp);
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = host_rdata;
                1: act = tim_rd_o;
                2: act = tim_wr_o;
                3: act = {8'h00, setup_o};
                4: act = {15'd0, cfg_open};
                default: act = {15'd0, drv_rd | drv_wr};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_item(int k, logic [15:0] e, string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        q.push_back(it);
    endtask

    task automatic access(bit rd, bit wr, bit wide, logic [2:0] a, logic [15:0] d,
                          bit chk_rd, logic [15:0] exp_rd, bit chk_fwd, bit exp_fwd, string t);
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_wide = wide; host_addr = a; host_wdata = d;
        #(PERIOD/4);
        if (chk_rd)  expect_item(0, exp_rd, t);
        if (chk_fwd) expect_item(5, {15'd0, exp_fwd}, t);
        -> smp;
        #1;
        @(posedge clk);
        #1;
        host_rd = 0; host_wr = 0;
    endtask

    task automatic cfg_write(logic [2:0] a, logic [7:0] v);
        access(0, 1, 0, a, {8'h00, v}, 0, 0, 0, 0, "");
    endtask

    task automatic cfg_read(logic [2:0] a, logic [15:0] e, string t);
        access(1, 0, 0, a, 0, 1, e, 1, 0, t);
    endtask

    task automatic snapshot(logic [15:0] trd, logic [15:0] twr, logic [7:0] su, bit op, string t);
        @(negedge clk);
        #(PERIOD/4);
        expect_item(1, trd, t);
        expect_item(2, twr, t);
        expect_item(3, {8'h00, su}, t);
        expect_item(4, {15'd0, op}, t);
        -> smp;
        #1;
    endtask

    task automatic unlock();
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(0, 1, 0, 3'd2, 16'h0003, 0, 0, 0, 0, "");
    endtask

    task automatic do_reset(bit strap);
        strap_clk25 = strap;
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        // R1 reset state
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 0, "R1 reset");

        // R2 pass-through while locked
        access(1, 0, 0, 3'd3, 0, 1, 16'hA503, 1, 1, "R2 locked read");
        access(0, 1, 1, 3'd4, 16'h1234, 0, 0, 1, 1, "R2 locked write");

        // R4 broken sequences
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(1, 0, 0, 3'd1, 0, 0, 0, 0, 0, "");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(0, 1, 0, 3'd2, 16'h0003, 0, 0, 0, 0, "");
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 0, "R4 byte read breaks");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(0, 1, 0, 3'd2, 16'h0004, 0, 0, 0, 0, "");
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 0, "R4 wrong value");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(1, 0, 1, 3'd2, 0, 0, 0, 0, 0, "");
        access(1, 0, 1, 3'd1, 0, 0, 0, 0, 0, "");
        access(0, 1, 0, 3'd2, 16'h0003, 0, 0, 0, 0, "");
        access(1, 0, 0, 3'd0, 0, 1, 16'hA500, 1, 1, "R4 other offset still locked");

        // R3 unlock
        unlock();
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 1, "R3 opened");
        // R5 no forwarding, config read
        cfg_read(3'd0, 16'h00FF, "R5 timing read while open");
        access(0, 1, 0, 3'd4, 16'h0077, 0, 0, 1, 0, "R5 write not forwarded");
        cfg_read(3'd7, 16'h0000, "R5 unused offset");

        // R9 strap
        cfg_read(3'd5, 16'h0001, "R9 strap 25MHz");
        cfg_write(3'd5, 8'h00);
        cfg_read(3'd5, 16'h0001, "R9 strap write ignored");

        // R6 bank select
        cfg_write(3'd6, 8'h20);
        cfg_write(3'd0, 8'h59);
        cfg_write(3'd1, 8'h46);
        cfg_write(3'd6, 8'h21);
        cfg_write(3'd0, 8'h30);
        cfg_write(3'd1, 8'h20);
        cfg_read(3'd0, 16'h0030, "R6 bank1 read timing");
        cfg_read(3'd1, 16'h0020, "R6 bank1 write timing");
        cfg_write(3'd6, 8'h20);
        cfg_read(3'd0, 16'h0059, "R6 bank0 read timing");
        cfg_read(3'd1, 16'h0046, "R6 bank0 write timing");
        cfg_read(3'd6, 16'h0020, "R5 misc readback");

        // R7 non-commit control value
        cfg_write(3'd3, 8'h84);
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 1, "R7 no commit on 0x84");
        cfg_read(3'd3, 16'h0084, "R5 control readback");

        // R7 R8 commit
        cfg_write(3'd3, 8'h85);
        snapshot(16'h3059, 16'h2046, 8'h20, 1, "R7 R8 commit");

        // R10 relock
        cfg_write(3'd2, 8'h03);
        snapshot(16'h3059, 16'h2046, 8'h20, 1, "R10 other value keeps open");
        cfg_write(3'd2, 8'h83);
        snapshot(16'h3059, 16'h2046, 8'h20, 0, "R10 relocked");
        access(1, 0, 1, 3'd0, 0, 1, 16'hA500, 1, 1, "R10 pass-through back");

        // R1 R9 strap captured as 0
        do_reset(1'b0);
        snapshot(16'hFFFF, 16'hFFFF, 8'h30, 0, "R1 second reset");
        unlock();
        cfg_read(3'd5, 16'h0000, "R9 strap 33MHz");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule